// File: doc/BRIEF.md
# Double-Edge Burst CRC-16 Accumulator

This block keeps a running 16-bit cyclic redundancy check over every data word moved during one Ultra DMA burst segment. A segment is the time the active-low acknowledge level stays asserted. The block works from two inputs: that level, and a one-cycle update pulse that comes with each 16-bit word. Edge detection upstream raises one pulse for every valid strobe transition. A rising and a falling strobe edge therefore each advance the checksum once.

When the acknowledge level is asserted, the register is loaded with the seed 16'h4ABA. Each accepted word is folded in with one combinational 16-bit step of the generator x^16 + x^12 + x^5 + 1 (mask 16'h1021), most significant data bit first. When the acknowledge level is released, the running value is latched as the final word. On the host side this word is driven onto the data lines. On the device side the same edge compares a received check word with the local value and sets a sticky mismatch flag.

Top module: `ucrc_burst`

## Requirements
- R1: After reset, `crc_now` is 16'h4ABA, `crc_final` is 16'h0000 and `crc_err` is 0.
- R2: In the cycle where `seg_ack_n` first reads low with no update pulse, the register is loaded with 16'h4ABA, and this value shows on `crc_now` one cycle later.
- R3: While `seg_ack_n` is low, each `strobe_evt` pulse replaces `crc_now` with the step of (`crc_now`, `word_in`) one cycle later. The step processes `word_in` bit 15 first, with mask 16'h1021.
- R4: Back-to-back pulses each fold in one word, and a cycle with no pulse inside the segment leaves `crc_now` unchanged. This lets both strobe edge directions contribute.
- R5: A `strobe_evt` pulse while `seg_ack_n` is high is ignored, so `crc_now` is unchanged on the next cycle.
- R6: In the cycle where `seg_ack_n` first reads high after being low, `crc_final` takes the value of `crc_now` and holds it until the next segment ends.
- R7: At that same segment end, `crc_err` is set if `crc_rx` differs from `crc_now`. It is not set when they are equal.
- R8: `crc_err` stays set until an `err_clr` pulse. A mismatch in the same cycle as `err_clr` wins, and the flag stays set.
- R9: An update pulse in the first low cycle of `seg_ack_n` is folded into the seed, so `crc_now` becomes the step of (16'h4ABA, `word_in`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_ack_n | input | 1 | Active-low segment level (DMA acknowledge) |
| strobe_evt | input | 1 | One-cycle pulse per valid strobe edge |
| word_in | input | 16 | Data word moved on that edge |
| crc_rx | input | 16 | Check word received from the far end |
| err_clr | input | 1 | Clear pulse for the mismatch flag |
| crc_now | output | 16 | Running check value |
| crc_final | output | 16 | Check value latched at segment end |
| crc_err | output | 1 | Sticky mismatch flag |

## Verification
A wrong register value shows on `crc_now` one cycle after the update that produced it. Because every later step depends on it, the error never recovers until the next reseed. A bad seed or a dropped or extra update shows the same way. It also reaches `crc_final` and `crc_err` at the next segment end. A lost previous-level bit moves the seed and latch points. Because of that, the bench compares all three outputs in every cycle against its own model, and does not wait for segment ends.

// File: rtl/ucrc_pkg.sv
package ucrc_pkg;
  localparam int CRC_W = 16;
  typedef logic [CRC_W-1:0] crc_t;

  // One full-word step, data MSB first, Galois-style feedback per bit.
  function automatic crc_t crc_word_step(input crc_t cur, input crc_t data, input crc_t poly);
    crc_t r;
    logic fb;
    r = cur;
    for (int i = CRC_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ data[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/ucrc_seg_track.sv
module ucrc_seg_track (
  input  logic clk,
  input  logic rst_n,
  input  logic seg_ack_n,
  output logic seg_act,
  output logic seg_start,
  output logic seg_end
);
  logic act_q;

  assign seg_act   = ~seg_ack_n;
  assign seg_start = seg_act & ~act_q;
  assign seg_end   = ~seg_act & act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= seg_act;
  end
endmodule

// File: rtl/ucrc_accum.sv
module ucrc_accum
  import ucrc_pkg::*;
#(
  parameter crc_t SEED = 16'h4ABA,
  parameter crc_t POLY = 16'h1021
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seg_start,
  input  logic step_en,
  input  crc_t word_in,
  output crc_t crc_q
);
  crc_t base, nxt;

  always_comb begin
    base = seg_start ? SEED : crc_q;
    nxt  = step_en ? crc_word_step(base, word_in, POLY) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= SEED;
    else        crc_q <= nxt;
  end
endmodule

// File: rtl/ucrc_close.sv
module ucrc_close
  import ucrc_pkg::*;
#(
  parameter bit CHECK_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seg_end,
  input  crc_t crc_run,
  input  crc_t crc_rx,
  input  logic err_clr,
  output crc_t crc_final,
  output logic crc_err,
  output logic mism
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_final <= '0;
    else if (seg_end) crc_final <= crc_run;
  end

  generate
    if (CHECK_EN) begin : g_check
      assign mism = seg_end && (crc_rx != crc_run);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       crc_err <= 1'b0;
        else if (mism)    crc_err <= 1'b1;
        else if (err_clr) crc_err <= 1'b0;
      end
    end else begin : g_nocheck
      logic unused_in;
      assign unused_in = ^{crc_rx, err_clr};
      assign mism      = 1'b0;
      assign crc_err   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ucrc_burst.sv
module ucrc_burst
  import ucrc_pkg::*;
#(
  parameter crc_t SEED     = 16'h4ABA,
  parameter crc_t POLY     = 16'h1021,
  parameter bit   CHECK_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seg_ack_n,
  input  logic        strobe_evt,
  input  logic [15:0] word_in,
  input  logic [15:0] crc_rx,
  input  logic        err_clr,
  output logic [15:0] crc_now,
  output logic [15:0] crc_final,
  output logic        crc_err
);
  logic seg_act, seg_start, seg_end, step_en, mism;

  assign step_en = seg_act & strobe_evt;

  ucrc_seg_track u_seg (
    .clk(clk), .rst_n(rst_n), .seg_ack_n(seg_ack_n),
    .seg_act(seg_act), .seg_start(seg_start), .seg_end(seg_end)
  );

  ucrc_accum #(.SEED(SEED), .POLY(POLY)) u_acc (
    .clk(clk), .rst_n(rst_n), .seg_start(seg_start), .step_en(step_en),
    .word_in(word_in), .crc_q(crc_now)
  );

  ucrc_close #(.CHECK_EN(CHECK_EN)) u_close (
    .clk(clk), .rst_n(rst_n), .seg_end(seg_end), .crc_run(crc_now),
    .crc_rx(crc_rx), .err_clr(err_clr), .crc_final(crc_final),
    .crc_err(crc_err), .mism(mism)
  );
endmodule

// File: rtl/ucrc_burst_chk.sv
module ucrc_burst_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        seg_act,
  input logic        seg_start,
  input logic        seg_end,
  input logic        step_en,
  input logic        mism,
  input logic        err_clr,
  input logic [15:0] crc_now,
  input logic [15:0] crc_final,
  input logic        crc_err
);
  p_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seg_start && !step_en |=> crc_now == 16'h4ABA);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seg_act && !seg_start && !step_en |=> $stable(crc_now));

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_act |=> $stable(crc_now));

  p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seg_end |=> crc_final == $past(crc_now));

  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_end |=> $stable(crc_final));

  p_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mism |=> crc_err);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err && !err_clr |=> crc_err);
endmodule

bind ucrc_burst ucrc_burst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .seg_act(seg_act), .seg_start(seg_start),
  .seg_end(seg_end), .step_en(step_en), .mism(mism), .err_clr(err_clr),
  .crc_now(crc_now), .crc_final(crc_final), .crc_err(crc_err)
);

// File: tb/tb_ucrc_burst.sv
`timescale 1ns/1ps
module tb_ucrc_burst;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_ack_n = 1'b1;
  logic        strobe_evt = 1'b0;
  logic [15:0] word_in = '0;
  logic [15:0] crc_rx = '0;
  logic        err_clr = 1'b0;
  logic [15:0] crc_now, crc_final;
  logic        crc_err;

  int n_vec = 0;
  int n_bad = 0;

  logic [15:0] m_crc = 16'h4ABA;
  logic [15:0] m_fin = '0;
  logic        m_err = 1'b0;
  logic        m_prev = 1'b0;

  always #2.5 clk = ~clk;

  ucrc_burst dut (
    .clk(clk), .rst_n(rst_n), .seg_ack_n(seg_ack_n), .strobe_evt(strobe_evt),
    .word_in(word_in), .crc_rx(crc_rx), .err_clr(err_clr),
    .crc_now(crc_now), .crc_final(crc_final), .crc_err(crc_err)
  );

  // Reference step: XOR the whole word in, then shift out 16 bits.
  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    r = c ^ d;
    for (int k = 0; k < 16; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic cmp16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string t_now, input string t_fin, input string t_err);
    cmp16(t_now, crc_now, m_crc);
    cmp16(t_fin, crc_final, m_fin);
    cmp16(t_err, {15'b0, crc_err}, {15'b0, m_err});
  endtask

  // Drive at negedge, let one posedge pass, update model, sample at next negedge.
  task automatic apply(input logic ack_n, input logic up, input logic [15:0] w,
                       input logic [15:0] rx, input logic clr,
                       input string t_now, input string t_fin, input string t_err);
    logic act, st, en, mm;
    logic [15:0] old;
    seg_ack_n = ack_n; strobe_evt = up; word_in = w; crc_rx = rx; err_clr = clr;
    act = !ack_n; st = act && !m_prev; en = act && !m_prev ? 1'b0 : 1'b0;
    en = !act && m_prev;
    old = m_crc;
    if (st) m_crc = 16'h4ABA;
    if (act && up) m_crc = ref_step(m_crc, w);
    mm = en && (rx != old);
    if (en) m_fin = old;
    m_err = mm | (m_err & !clr);
    m_prev = act;
    @(posedge clk);
    @(negedge clk);
    check_all(t_now, t_fin, t_err);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] sv_fin;
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    check_all("R1 now", "R1 final", "R1 err");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 now", "R1 final", "R1 err");

    // R5: update while idle is ignored
    apply(1, 1, 16'hFFFF, 0, 0, "R5 idle update", "R6 final", "R7 err");
    cmp16("R5 idle value", crc_now, 16'h4ABA);
    // R2: seed with no update
    apply(0, 0, 16'h1234, 0, 0, "R2 seed", "R6 final", "R7 err");
    cmp16("R2 seed value", crc_now, 16'h4ABA);
    // R3/R4: consecutive updates, then a gap
    apply(0, 1, 16'h0001, 0, 0, "R3 step", "R6 final", "R7 err");
    apply(0, 1, 16'h8000, 0, 0, "R4 back-to-back", "R6 final", "R7 err");
    apply(0, 0, 16'hAAAA, 0, 0, "R4 gap", "R6 final", "R7 err");
    // R7: matching close leaves flag clear
    apply(1, 0, 0, m_crc, 0, "R5 close", "R6 latch", "R7 match");
    sv_fin = m_fin;
    cmp16("R6 latch value", crc_final, sv_fin);
    // R9: update in the first segment cycle
    apply(0, 1, 16'hC0DE, 0, 0, "R9 first-cycle", "R6 hold", "R7 err");
    cmp16("R9 value", crc_now, ref_step(16'h4ABA, 16'hC0DE));
    cmp16("R6 hold value", crc_final, sv_fin);
    // R7/R8: mismatch, then clear colliding with a new mismatch
    apply(1, 0, 0, ~m_crc, 0, "R5 close", "R6 latch", "R7 mismatch");
    apply(1, 1, 16'h5555, 0, 0, "R5 idle", "R6 hold", "R8 sticky");
    apply(0, 1, 16'h0F0F, 0, 0, "R9 first-cycle", "R6 hold", "R8 sticky");
    apply(1, 0, 0, ~m_crc, 1, "R5 close", "R6 latch", "R8 set wins");
    apply(1, 0, 0, 0, 1, "R5 idle", "R6 hold", "R8 clear");

    // Constrained random segments
    for (int i = 0; i < 4000; i++) begin
      logic ack_n, up, clr;
      logic [15:0] rx;
      ack_n = (m_prev ? ($urandom_range(0, 15) == 0) : ($urandom_range(0, 3) != 0));
      up  = $urandom_range(0, 1);
      clr = ($urandom_range(0, 7) == 0);
      rx  = ($urandom_range(0, 1) == 0) ? m_crc : 16'($urandom);
      apply(ack_n, up, 16'($urandom), rx, clr, "R3 random", "R6 random", "R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule